// File: doc/BRIEF.md
# Iterative Shift-and-Add Integer Multiplier

This block multiplies two integer operands one multiplier bit per clock cycle and returns a product twice the operand width. A 32-bit pair gives a 64-bit result. The caller presents both operands and a mode select, then pulses `start`. The block holds `busy` high while it iterates. It then pulses `done` and keeps the product on two half-width output words until the next operation is accepted.

Each iteration makes one decision. If the lowest bit of the shifting multiplier is set, the double-width multiplicand register is added into the accumulator. In the same cycle the multiplicand moves one place left and the multiplier moves one place right. In signed mode the block takes the absolute values of both operands and records whether their signs differ. If they differ, it negates the finished magnitude product on the final iteration. No extra cycle is spent on the sign.

Top module: `seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both product words are 0.
- R2: When `start` is 1 while `busy` is 0, the operands and `op_signed` are captured on that clock edge, and `busy` reads 1 after it.
- R3: `done` rises on the W-th clock edge after the edge that accepted `start`. It is high for exactly one cycle, and `busy` falls on that same edge.
- R4: With `op_signed` = 0, the operands are treated as unsigned. {`prod_hi`,`prod_lo`} equals their full 2W-bit unsigned product.
- R5: With `op_signed` = 1, the operands are treated as two's complement. {`prod_hi`,`prod_lo`} equals their 2W-bit two's-complement product. This holds for the most negative value (0x80000000 for W=32) and for zero operands.
- R6: A `start` pulse while `busy` is 1 has no effect. The running operation keeps its operands, mode and completion time.
- R7: While `busy` is 0 and no `start` is accepted, the product outputs hold their value.
- R8: `prod_hi` carries bits 2W-1..W of the product and `prod_lo` carries bits W-1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply, taken only when idle |
| op_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| prod_hi | output | W | Upper half of the product |
| prod_lo | output | W | Lower half of the product |

## Verification
The bench builds the block with its default width W=32. This makes the most negative operand 0x80000000 and the all-ones unsigned operands directly reachable. Their squares exercise the top product bit and the 64-bit negation path. Random operand pairs in both modes cover many carry patterns through the accumulator. The 32-cycle window is long enough that stray `start` pulses can be placed early, in the middle and on the final iteration.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_signed,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int PW = 2 * W;
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [PW-1:0] mcand, acc;
  logic [W-1:0]  mplier;
  logic [CW-1:0] cnt;
  logic          neg, busy_q, done_q;

  wire           accept = start & ~busy_q;
  wire           last   = (cnt == CW'(W - 1));
  wire [W-1:0]   mag_a  = (op_signed && op_a[W-1]) ? -op_a : op_a;
  wire [W-1:0]   mag_b  = (op_signed && op_b[W-1]) ? -op_b : op_b;
  wire [PW-1:0]  acc_nx = mplier[0] ? acc + mcand : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      cnt    <= '0;
      neg    <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mcand  <= {{W{1'b0}}, mag_a};
        mplier <= mag_b;
        acc    <= '0;
        cnt    <= '0;
        neg    <= op_signed & (op_a[W-1] ^ op_b[W-1]);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + CW'(1);
        if (last) begin
          acc    <= neg ? -acc_nx : acc_nx;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          acc <= acc_nx;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign prod_hi = acc[PW-1:W];
  assign prod_lo = acc[W-1:0];

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_first_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == '0));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(neg));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({prod_hi, prod_lo}));
endmodule

// File: tb/seq_mul_bench.sv
module seq_mul_bench;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op_signed = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  int checks = 0;
  int errors = 0;

  seq_mul #(.W(W)) u_seq_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic sg);
    logic signed [2*W-1:0] sa, sb;
    logic [2*W-1:0] ua, ub;
    if (sg) begin
      sa = {{W{a[W-1]}}, a};
      sb = {{W{b[W-1]}}, b};
      return sa * sb;
    end
    ua = {{W{1'b0}}, a};
    ub = {{W{1'b0}}, b};
    return ua * ub;
  endfunction

  task automatic check(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stray: 0 none, otherwise inject a start with other operands after that many cycles
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic sg, int stray);
    logic [2*W-1:0] exp;
    int k;
    exp = ref_mul(a, b, sg);
    op_a = a; op_b = b; op_signed = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; op_signed = ~sg;
    k = 1;
    check(busy === 1'b1 && done === 1'b0, "R2", {62'd0, busy, done}, 64'd2);
    while (done !== 1'b1 && k < 3 * W) begin
      if (stray != 0 && k == stray) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    check(k == W + 1, "R3 latency", 64'(k), 64'(W + 1));
    check(busy === 1'b0, "R3 busy low with done", {63'd0, busy}, 64'd0);
    check({prod_hi, prod_lo} === exp, sg ? (stray != 0 ? "R6 R5" : "R5") : (stray != 0 ? "R6 R4" : "R4"),
          {prod_hi, prod_lo}, exp);
    check(prod_hi === exp[2*W-1:W] && prod_lo === exp[W-1:0], "R8", {prod_hi, prod_lo}, exp);
    @(negedge clk);
    check(done === 1'b0, "R3 pulse", {63'd0, done}, 64'd0);
    op_a = $urandom; op_b = $urandom;
    @(negedge clk);
    check({prod_hi, prod_lo} === exp, "R7 hold", {prod_hi, prod_lo}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && {prod_hi, prod_lo} === '0, "R1",
          {prod_hi, prod_lo} | {62'd0, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'd2, 32'd3, 1'b0, 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 0);
    run_op(32'h8000_0000, 32'd1, 1'b1, 0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0);
    run_op(32'd0, 32'h8000_0000, 1'b1, 0);
    run_op(32'hFFFF_FFF9, 32'd0, 1'b1, 0);
    run_op(32'hFFFF_FFF9, 32'd2, 1'b1, 0);
    run_op(32'd7, 32'hFFFF_FFFE, 1'b1, 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 0);
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 3);
    run_op(32'h8000_0001, 32'h7FFF_FFFF, 1'b1, W);
    run_op(32'hDEAD_BEEF, 32'h0000_0001, 1'b1, 17);

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 10 == 0) ra = 32'h8000_0000;
      if (i % 13 == 0) rb = '0;
      run_op(ra, rb, 1'($urandom % 2), (i % 7 == 0) ? int'(1 + $urandom % W) : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule